// File: doc/BRIEF.md
# Master Clock Selection and Processor Clock Divider

This block keeps two control fields for the clocking of a processor subsystem and acts on them. The first is a pair of frequency-select bits. Together they name the master clock rate that downstream logic should assume. These bits are sticky: software can set them, but only a reset clears them. The block turns them into a small status code and does not touch any oscillator.

The second field is a 3-bit divider code. It sets how often a one-cycle processor clock enable fires in the master clock domain. Software may rewrite the code at any moment. The new ratio is applied only when the divide period in progress ends, so the enable never fires early and never skips a period.

Access is through a simple register port. A write strobe carries an address and data. The read data is a combinational function of a read address. Both fields are also driven out on dedicated pins.

Top module: `clkctl`

## Requirements
- R1: The output `mck_sel` decodes the frequency bits `{upper, lower}`: 00 gives code 0 (20 MHz), 01 gives code 1 (26.7 MHz), and 10 or 11 gives code 2 (40 MHz). Code 3 never appears.
- R2: While reset is high and in the first cycle after it, both frequency bits are 0, the divider code is 000 and `mck_sel` is 0. `cpu_tick` is low during reset. The first tick is high in the third cycle after reset release, which is a divide-by-4 phase.
- R3: A write to address 0 ORs `wr_data[1:0]` into the frequency bits. A zero in any written bit leaves that bit unchanged, so a set bit stays set until reset.
- R4: Divider codes 000 through 101 make the tick period 4, 8, 16, 32, 64 and 128 master cycles. Codes 110 and 111 both make it 256 cycles.
- R5: `cpu_tick` is high for exactly one cycle per period. Consecutive ticks are exactly the active period apart.
- R6: A divider write takes effect at the first tick edge after the write. The period in progress keeps the old length. A write captured on the same clock edge as a tick applies one period later, so one more full period of the old length follows before the new one.
- R7: A write to address 1 loads `wr_data[2:0]` into the divider code on the next edge. Read address 0 returns the frequency bits in `rd_data[1:0]`, and read address 1 returns the divider code in `rd_data[2:0]`. All other read bits and other read addresses return zero. `freq_bits` and `div_code` always show the held values.
- R8: Writes to addresses other than 0 and 1 change neither field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address (0 frequency, 1 divider) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| mck_sel | output | 2 | Decoded master clock rate code |
| cpu_tick | output | 1 | One-cycle processor clock enable |
| freq_bits | output | 2 | Held frequency-select bits |
| div_code | output | 3 | Held divider code |

## Verification
A divider write and a period boundary can fall on the same clock edge. The question is then whether the boundary takes the old code or the new one. The bench provokes this by waiting a number of cycles after a tick equal to the old period before it presents the write, so the capturing edge is the tick edge. The scoreboard then expects two old-length intervals before the new length. Writes captured earlier in the period are expected to give one old-length interval, and these are checked across every divider code.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int FREQ_W       = 2;
    localparam int DIV_CODE_W   = 3;
    localparam int DIV_MIN_LOG2 = 2;
    localparam int DIV_MAX_LOG2 = 8;
    localparam int CNT_W        = DIV_MAX_LOG2;

    typedef logic [FREQ_W-1:0]     freq_t;
    typedef logic [DIV_CODE_W-1:0] div_code_t;
    typedef logic [CNT_W-1:0]      cnt_t;

    typedef enum logic [1:0] {
        MCK_20M   = 2'd0,
        MCK_26M7  = 2'd1,
        MCK_40M   = 2'd2
    } mck_sel_e;

    typedef enum logic [1:0] {
        REG_FREQ = 2'd0,
        REG_DIV  = 2'd1
    } reg_sel_e;

    typedef struct packed {
        freq_t     freq;
        div_code_t div;
    } ctl_state_t;

    // Last count value of a divide period for a given code.
    function automatic cnt_t period_last(div_code_t code);
        int unsigned lg;
        lg = DIV_MIN_LOG2 + int'(code);
        if (lg > DIV_MAX_LOG2) lg = DIV_MAX_LOG2;
        return cnt_t'((32'd1 << lg) - 32'd1);
    endfunction

    function automatic mck_sel_e decode_freq(freq_t f);
        if (f[1])      return MCK_40M;
        else if (f[0]) return MCK_26M7;
        else           return MCK_20M;
    endfunction

endpackage

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output ctl_state_t        state
);

    localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(REG_FREQ);
    localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(REG_DIV);

    logic wr_freq;
    logic wr_div;
    logic unused_wr_hi;

    assign wr_freq      = wr_en && (wr_addr == A_FREQ);
    assign wr_div       = wr_en && (wr_addr == A_DIV);
    assign unused_wr_hi = ^wr_data;

    // Set-only frequency bits, one flop per bit.
    for (genvar b = 0; b < FREQ_W; b++) begin : g_sticky
        always_ff @(posedge clk) begin
            if (rst)
                state.freq[b] <= 1'b0;
            else if (wr_freq && wr_data[b])
                state.freq[b] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            state.div <= '0;
        else if (wr_div)
            state.div <= wr_data[DIV_CODE_W-1:0];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_FREQ)
            rd_data[FREQ_W-1:0] = state.freq;
        else if (rd_addr == A_DIV)
            rd_data[DIV_CODE_W-1:0] = state.div;
    end

endmodule

// File: rtl/clkctl_tick_gen.sv
module clkctl_tick_gen
    import clkctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  div_code_t div_req,
    output logic      tick
);

    cnt_t      cnt_q;
    div_code_t div_act_q;
    cnt_t      last;

    assign last = period_last(div_act_q);
    assign tick = (cnt_q == last);

    // The requested code is adopted only at a period boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            div_act_q <= '0;
        end else if (tick) begin
            cnt_q     <= '0;
            div_act_q <= div_req;
        end else begin
            cnt_q <= cnt_q + cnt_t'(1);
        end
    end

endmodule

// File: rtl/clkctl_freq_decode.sv
module clkctl_freq_decode
    import clkctl_pkg::*;
(
    input  freq_t    freq,
    output mck_sel_e sel
);

    assign sel = decode_freq(freq);

endmodule

// File: rtl/clkctl.sv
module clkctl
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        mck_sel,
    output logic              cpu_tick,
    output logic [1:0]        freq_bits,
    output logic [2:0]        div_code
);

    ctl_state_t st;
    mck_sel_e   sel;

    clkctl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .state   (st)
    );

    clkctl_tick_gen u_tick (
        .clk     (clk),
        .rst     (rst),
        .div_req (st.div),
        .tick    (cpu_tick)
    );

    clkctl_freq_decode u_dec (
        .freq (st.freq),
        .sel  (sel)
    );

    assign mck_sel   = sel;
    assign freq_bits = st.freq;
    assign div_code  = st.div;

endmodule

// File: rtl/clkctl_sva.sv
module clkctl_sva #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        mck_sel,
    input logic              cpu_tick,
    input logic [1:0]        freq_bits,
    input logic [2:0]        div_code
);

    logic [8:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || cpu_tick)
            gap_q <= '0;
        else if (gap_q != 9'h1FF)
            gap_q <= gap_q + 9'd1;
    end

    assert_reset_clear_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (freq_bits == 2'b00 && div_code == 3'b000 && mck_sel == 2'd0));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        ((freq_bits & $past(freq_bits)) == $past(freq_bits)));

    assert_sel_40_R1: assert property (@(posedge clk) disable iff (rst)
        freq_bits[1] |-> mck_sel == 2'd2);

    assert_sel_26_R1: assert property (@(posedge clk) disable iff (rst)
        (freq_bits == 2'b01) |-> mck_sel == 2'd1);

    assert_sel_20_R1: assert property (@(posedge clk) disable iff (rst)
        (freq_bits == 2'b00) |-> mck_sel == 2'd0);

    assert_tick_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        cpu_tick |=> !cpu_tick);

    assert_tick_gap_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_tick |-> gap_q >= 9'd3);

    assert_div_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_W'(1)) |=> div_code == $past(wr_data[2:0]));

    assert_other_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr > ADDR_W'(1)) |=> ($stable(div_code) && $stable(freq_bits)));

endmodule

bind clkctl clkctl_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .mck_sel   (mck_sel),
    .cpu_tick  (cpu_tick),
    .freq_bits (freq_bits),
    .div_code  (div_code)
);

// File: tb/clkctl_tb.sv
module clkctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic [1:0]        mck_sel;
    logic              cpu_tick;
    logic [1:0]        freq_bits;
    logic [2:0]        div_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    int exp_q[$];
    int cur_code = 0;
    int gap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .mck_sel   (mck_sel),
        .cpu_tick  (cpu_tick),
        .freq_bits (freq_bits),
        .div_code  (div_code)
    );

    function automatic int period_of(int code);
        return (code >= 6) ? 256 : (4 << code);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: measure tick spacing and compare against scoreboard.
    always @(negedge clk) begin
        if (rst) begin
            gap = 0;
        end else begin
            gap++;
            if (cpu_tick) begin
                if (exp_q.size() > 0) begin
                    int e;
                    e = exp_q.pop_front();
                    check(gap == e, "R4 R5 R6 tick spacing", gap, e);
                end
                gap = 0;
            end
        end
    end

    task automatic write_reg(int addr, int data);
        wr_en   = 1'b1;
        wr_addr = ADDR_W'(addr);
        wr_data = DATA_W'(data);
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic read_chk(int addr, int expv, string req);
        rd_addr = ADDR_W'(addr);
        #1;
        check(int'(rd_data) == expv, req, int'(rd_data), expv);
    endtask

    // Driver: write a new code d cycles after a tick, push expected spacings.
    task automatic set_div(int code, int d, int k);
        int pold;
        int pnew;
        while (exp_q.size() != 0) @(negedge clk);
        do @(negedge clk); while (!cpu_tick);
        @(negedge clk);
        pold = period_of(cur_code);
        pnew = period_of(code);
        exp_q.push_back(pold);
        if (d == pold) exp_q.push_back(pold);
        for (int i = 0; i < k; i++) exp_q.push_back(pnew);
        repeat (d - 1) @(negedge clk);
        write_reg(1, code);
        cur_code = code;
        check(int'(div_code) == code, "R7 div_code output", int'(div_code), code);
        read_chk(1, code, "R7 div readback");
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(cpu_tick == 1'b0, "R2 tick low in reset", int'(cpu_tick), 0);
        check(freq_bits == 2'b00, "R2 freq bits reset", int'(freq_bits), 0);
        check(div_code == 3'b000, "R2 div code reset", int'(div_code), 0);
        check(mck_sel == 2'd0, "R2 mck_sel reset", int'(mck_sel), 0);
        rst = 1'b0;
        cur_code = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int first;
        do_reset();
        // R2: first tick in the third cycle after release.
        first = 0;
        do begin @(negedge clk); first++; end while (!cpu_tick && first < 20);
        check(first == 3, "R2 first tick position", first, 3);
        read_chk(0, 0, "R7 freq readback after reset");
        read_chk(1, 0, "R7 div readback after reset");

        // R4 R6: every code, write early in the period.
        for (int c = 1; c < 8; c++) set_div(c, 1, 2);
        set_div(0, 2, 3);
        // R6: mid-period write.
        set_div(3, 3, 2);
        // R6: write landing on the tick edge.
        set_div(1, period_of(cur_code), 2);
        set_div(6, period_of(cur_code), 1);
        set_div(5, 100, 2);
        set_div(7, period_of(cur_code), 1);

        // R8: writes to unused addresses.
        write_reg(2, 8'hFF);
        write_reg(3, 8'hFF);
        check(int'(div_code) == 7, "R8 div unchanged", int'(div_code), 7);
        check(freq_bits == 2'b00, "R8 freq unchanged", int'(freq_bits), 0);
        read_chk(2, 0, "R7 unused address reads zero");
        read_chk(3, 0, "R7 unused address reads zero");

        // R3 R1: sticky frequency bits.
        write_reg(0, 0);
        check(freq_bits == 2'b00, "R3 zero write", int'(freq_bits), 0);
        check(mck_sel == 2'd0, "R1 20 MHz code", int'(mck_sel), 0);
        write_reg(0, 1);
        check(mck_sel == 2'd1, "R1 26.7 MHz code", int'(mck_sel), 1);
        read_chk(0, 1, "R7 freq readback");
        write_reg(0, 0);
        check(freq_bits == 2'b01, "R3 zero write keeps bit", int'(freq_bits), 1);
        write_reg(0, 2);
        check(freq_bits == 2'b11, "R3 OR of new bit", int'(freq_bits), 3);
        check(mck_sel == 2'd2, "R1 40 MHz both bits", int'(mck_sel), 2);
        write_reg(0, 8'hFC);
        check(freq_bits == 2'b11, "R3 zeros ignored", int'(freq_bits), 3);
        read_chk(0, 3, "R7 freq readback sticky");

        // R1: upper bit alone, after a fresh reset.
        do_reset();
        write_reg(0, 2);
        check(mck_sel == 2'd2, "R1 40 MHz upper only", int'(mck_sel), 2);
        check(freq_bits == 2'b10, "R3 upper bit set", int'(freq_bits), 2);
        set_div(2, 1, 2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule